// File: doc/BRIEF.md
# Effective Address Generation Unit

This block turns a decoded addressing-mode code into a flat 32-bit memory address for a load or store. Alongside the mode code it takes a 32-bit constant from the instruction, the base and index register values read elsewhere, and a 2-bit scale select. One datapath serves every memory mode. The adder takes either zero or the base as one operand. The other operand is the constant, nothing, or the index shifted left.

The result is registered, so there is one cycle of latency. For a mode that reaches memory, the address appears together with a valid strobe. For a register or immediate operand mode, a separate flag reports that no memory access is wanted and valid stays low. An undefined code raises an illegal flag instead. All arithmetic wraps modulo 2^32.

Top module: `eaGenUnit`

## Requirements
- R1: Mode code 3'd0 (memory-direct): one cycle after `reqValid`, `eaAddr` equals `instConst` and `eaValid` is 1.
- R2: Mode code 3'd1 (register-indirect): one cycle after `reqValid`, `eaAddr` equals `baseVal` and `eaValid` is 1.
- R3: Mode code 3'd2 (base plus displacement): `eaAddr` equals `baseVal + instConst` modulo 2^32, with the constant treated as a signed 32-bit value. `eaValid` is 1.
- R4: Mode code 3'd3 (scaled index): `eaAddr` equals `baseVal + (indexVal << scaleSel)` modulo 2^32. `scaleSel` values 0, 1, 2 and 3 give factors 1, 2, 4 and 8. `eaValid` is 1.
- R5: Mode codes 3'd4 (register operand) and 3'd5 (immediate operand): one cycle after `reqValid`, `noMemAccess` is 1 while `eaValid` and `illegalMode` are 0.
- R6: Mode codes 3'd6 and 3'd7: one cycle after `reqValid`, `illegalMode` is 1 while `eaValid` and `noMemAccess` are 0.
- R7: In any cycle that follows a cycle with `reqValid` low, all three strobes are 0. At most one strobe is high in any cycle.
- R8: While reset is asserted and on the first cycle after it, all three strobes and `eaAddr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| modeCode | input | 3 | Addressing-mode code |
| instConst | input | 32 | Constant (address or displacement) from the instruction |
| baseVal | input | 32 | Base register value |
| indexVal | input | 32 | Index register value |
| scaleSel | input | 2 | Index shift amount, 0 to 3 |
| eaAddr | output | 32 | Registered effective address |
| eaValid | output | 1 | Address is valid for a memory access |
| noMemAccess | output | 1 | Requested mode has no memory operand |
| illegalMode | output | 1 | Requested mode code is undefined |

## Verification
The bench applies a negative displacement and sums past 2^32. A design that extended the constant with zeros, or kept a carry, would produce an address that is off by a power of two.

Each scale value is applied with an index whose top bits are set. This catches a scale table that is swapped, or a shift that keeps bits shifted past bit 31.

Non-memory and undefined codes are interleaved with memory modes. This shows that valid falls for them and that the flags never overlap. A design that decoded these codes as memory modes, or latched stale flags when `reqValid` is low, would be caught.

// File: rtl/eaGenPkg.sv
package eaGenPkg;
  localparam int ADDR_W  = 32;
  localparam int MODE_W  = 3;
  localparam int SCALE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_DIRECT  = 3'd0,
    MODE_REGIND  = 3'd1,
    MODE_BASEDSP = 3'd2,
    MODE_SCALED  = 3'd3,
    MODE_REGOP   = 3'd4,
    MODE_IMMOP   = 3'd5
  } modeT;

  typedef enum logic [1:0] {
    SRC_ZERO  = 2'd0,
    SRC_CONST = 2'd1,
    SRC_INDEX = 2'd2
  } addSrcT;

  typedef struct packed {
    logic   useBase;
    addSrcT addSrc;
    logic   loadValid;
    logic   loadNoMem;
    logic   loadIllegal;
  } ctrlT;
endpackage

// File: rtl/eaGenCtrl.sv
module eaGenCtrl
  import eaGenPkg::*;
(
  input  logic              reqValid,
  input  logic [MODE_W-1:0] modeCode,
  output ctrlT              ctrl
);
  always_comb begin
    ctrl = '{useBase: 1'b0, addSrc: SRC_ZERO, loadValid: 1'b0,
             loadNoMem: 1'b0, loadIllegal: 1'b0};
    if (reqValid) begin
      unique case (modeCode)
        MODE_DIRECT: begin
          ctrl.addSrc    = SRC_CONST;
          ctrl.loadValid = 1'b1;
        end
        MODE_REGIND: begin
          ctrl.useBase   = 1'b1;
          ctrl.loadValid = 1'b1;
        end
        MODE_BASEDSP: begin
          ctrl.useBase   = 1'b1;
          ctrl.addSrc    = SRC_CONST;
          ctrl.loadValid = 1'b1;
        end
        MODE_SCALED: begin
          ctrl.useBase   = 1'b1;
          ctrl.addSrc    = SRC_INDEX;
          ctrl.loadValid = 1'b1;
        end
        MODE_REGOP, MODE_IMMOP: ctrl.loadNoMem = 1'b1;
        default: ctrl.loadIllegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/eaGenDatapath.sv
module eaGenDatapath
  import eaGenPkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SW = SCALE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlT          ctrl,
  input  logic [AW-1:0] instConst,
  input  logic [AW-1:0] baseVal,
  input  logic [AW-1:0] indexVal,
  input  logic [SW-1:0] scaleSel,
  output logic [AW-1:0] eaAddr,
  output logic          eaValid,
  output logic          noMemAccess,
  output logic          illegalMode
);
  localparam int NSCALE = 1 << SW;

  logic [AW-1:0] shifted [NSCALE];
  logic [AW-1:0] opA, opB, sum;

  for (genvar s = 0; s < NSCALE; s++) begin : g_scale
    assign shifted[s] = indexVal << s;
  end

  always_comb begin
    opA = ctrl.useBase ? baseVal : '0;
    unique case (ctrl.addSrc)
      SRC_CONST: opB = instConst;
      SRC_INDEX: opB = shifted[scaleSel];
      default:   opB = '0;
    endcase
    sum = opA + opB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaAddr      <= '0;
      eaValid     <= 1'b0;
      noMemAccess <= 1'b0;
      illegalMode <= 1'b0;
    end else begin
      eaValid     <= ctrl.loadValid;
      noMemAccess <= ctrl.loadNoMem;
      illegalMode <= ctrl.loadIllegal;
      if (ctrl.loadValid) eaAddr <= sum;
    end
  end
endmodule

// File: rtl/eaGenUnit.sv
module eaGenUnit
  import eaGenPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [2:0]  modeCode,
  input  logic [31:0] instConst,
  input  logic [31:0] baseVal,
  input  logic [31:0] indexVal,
  input  logic [1:0]  scaleSel,
  output logic [31:0] eaAddr,
  output logic        eaValid,
  output logic        noMemAccess,
  output logic        illegalMode
);
  ctrlT ctrl;

  eaGenCtrl u_ctrl (
    .reqValid (reqValid),
    .modeCode (modeCode),
    .ctrl     (ctrl)
  );

  eaGenDatapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .instConst   (instConst),
    .baseVal     (baseVal),
    .indexVal    (indexVal),
    .scaleSel    (scaleSel),
    .eaAddr      (eaAddr),
    .eaValid     (eaValid),
    .noMemAccess (noMemAccess),
    .illegalMode (illegalMode)
  );
endmodule

// File: rtl/eaGenChecker.sv
module eaGenChecker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [2:0]  modeCode,
  input logic [31:0] instConst,
  input logic [31:0] baseVal,
  input logic [31:0] indexVal,
  input logic [1:0]  scaleSel,
  input logic [31:0] eaAddr,
  input logic        eaValid,
  input logic        noMemAccess,
  input logic        illegalMode
);
  logic pastRst;
  always_ff @(posedge clk) pastRst <= rstN;

  p_direct_r1: assert property (@(posedge clk) disable iff (!rstN || !pastRst)
    (reqValid && modeCode == 3'd0) |=> (eaValid && eaAddr == $past(instConst)));

  p_regind_r2: assert property (@(posedge clk) disable iff (!rstN || !pastRst)
    (reqValid && modeCode == 3'd1) |=> (eaValid && eaAddr == $past(baseVal)));

  p_basedsp_r3: assert property (@(posedge clk) disable iff (!rstN || !pastRst)
    (reqValid && modeCode == 3'd2) |=>
      (eaValid && eaAddr == 32'($past(baseVal) + $past(instConst))));

  p_scaled_r4: assert property (@(posedge clk) disable iff (!rstN || !pastRst)
    (reqValid && modeCode == 3'd3) |=>
      (eaValid && eaAddr == 32'($past(baseVal) + ($past(indexVal) << $past(scaleSel)))));

  p_nomem_r5: assert property (@(posedge clk) disable iff (!rstN || !pastRst)
    (reqValid && (modeCode == 3'd4 || modeCode == 3'd5)) |=>
      (noMemAccess && !eaValid && !illegalMode));

  p_illegal_r6: assert property (@(posedge clk) disable iff (!rstN || !pastRst)
    (reqValid && modeCode[2:1] == 2'b11) |=> (illegalMode && !eaValid && !noMemAccess));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rstN || !pastRst)
    !reqValid |=> (!eaValid && !noMemAccess && !illegalMode));

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({eaValid, noMemAccess, illegalMode}));

  p_reset_r8: assert property (@(posedge clk)
    $past(!rstN) |-> (!eaValid && !noMemAccess && !illegalMode && eaAddr == '0));
endmodule

bind eaGenUnit eaGenChecker u_chk (.*);

// File: tb/tb_eaGenUnit.sv
module tb_eaGenUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  modeCode = '0;
  logic [31:0] instConst = '0, baseVal = '0, indexVal = '0;
  logic [1:0]  scaleSel = '0;
  logic [31:0] eaAddr;
  logic        eaValid, noMemAccess, illegalMode;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  eaGenUnit dut (.*);

  task automatic chk(string req, logic [34:0] act, logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one request, sample mid-cycle after the capturing edge
  task automatic issue(logic [2:0] m, logic [31:0] c, logic [31:0] b,
                       logic [31:0] x, logic [1:0] s);
    @(negedge clk);
    reqValid = 1'b1; modeCode = m; instConst = c; baseVal = b;
    indexVal = x; scaleSel = s;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic testReset();
    chk("R8", {eaValid, noMemAccess, illegalMode, eaAddr}, '0);
  endtask

  task automatic testDirect();
    issue(3'd0, 32'h0000_2012, 32'hFFFF_FFFF, 32'h1, 2'd3);
    chk("R1", {eaValid, noMemAccess, illegalMode, eaAddr}, {3'b100, 32'h0000_2012});
  endtask

  task automatic testRegInd();
    issue(3'd1, 32'h1234, 32'h0000_200D, 32'h55, 2'd2);
    chk("R2", {eaValid, noMemAccess, illegalMode, eaAddr}, {3'b100, 32'h0000_200D});
  endtask

  task automatic testBaseDsp();
    issue(3'd2, 32'h0000_0010, 32'h0000_0080, 32'h0, 2'd0);
    chk("R3", {eaValid, eaAddr}, {1'b1, 32'h0000_0090});
    issue(3'd2, 32'hFFFF_FFF0, 32'h0000_0080, 32'h0, 2'd0); // -16
    chk("R3", {eaValid, eaAddr}, {1'b1, 32'h0000_0070});
    issue(3'd2, 32'h0000_0020, 32'hFFFF_FFF0, 32'h0, 2'd0); // wrap
    chk("R3", {eaValid, eaAddr}, {1'b1, 32'h0000_0010});
  endtask

  task automatic testScaled();
    for (int s = 0; s < 4; s++) begin
      issue(3'd3, 32'hDEAD, 32'h0000_1000, 32'hC000_0003, 2'(s));
      chk("R4", {eaValid, eaAddr},
          {1'b1, 32'h0000_1000 + (32'hC000_0003 << s)});
    end
    issue(3'd3, 32'h0, 32'hFFFF_FFF8, 32'h2, 2'd3); // wrap: -8 + 16
    chk("R4", {eaValid, eaAddr}, {1'b1, 32'h0000_0008});
  endtask

  task automatic testNoMem();
    issue(3'd4, 32'h1, 32'h2, 32'h3, 2'd0);
    chk("R5", {eaValid, noMemAccess, illegalMode}, 35'b010);
    issue(3'd5, 32'h1, 32'h2, 32'h3, 2'd0);
    chk("R5", {eaValid, noMemAccess, illegalMode}, 35'b010);
  endtask

  task automatic testIllegal();
    issue(3'd6, 32'h1, 32'h2, 32'h3, 2'd0);
    chk("R6", {eaValid, noMemAccess, illegalMode}, 35'b001);
    issue(3'd7, 32'h1, 32'h2, 32'h3, 2'd0);
    chk("R6", {eaValid, noMemAccess, illegalMode}, 35'b001);
  endtask

  task automatic testIdle();
    issue(3'd1, 32'h0, 32'hABCD, 32'h0, 2'd0);
    @(negedge clk); // reqValid low for the previous cycle
    chk("R7", {eaValid, noMemAccess, illegalMode}, 35'b000);
    issue(3'd6, 32'h0, 32'h0, 32'h0, 2'd0);
    @(negedge clk);
    chk("R7", {eaValid, noMemAccess, illegalMode}, 35'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testDirect();
    testRegInd();
    testBaseDsp();
    testScaled();
    testNoMem();
    testIllegal();
    testIdle();
    testDirect();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule